// File: doc/BRIEF.md
# Fault Signaling Output Controller

This block watches a set of fault lines from system sources and, optionally, a fault line from an external device. It turns them into one sticky fault-active state and drives a fault pin from that state. The pin has two uses. In heartbeat mode it toggles at a programmed rate while the system is healthy. It freezes once a fault is active, so an external supervisor sees the heartbeat stop. In fault mode the pin simply reports the fault-active state.

A programmable delay filters short glitches. A fault condition must stay present for a number of consecutive cycles before the state is declared active. If the condition drops earlier, the count starts over.

Software programs the block through a plain write/read register port with four word addresses. Interlocks make the block ignore configuration writes that would be unsafe:
- enabling the block while a fault is still latched;
- arming the external input while the block is running;
- arming the external input outside fault mode.

The fault lines, the external input and the pin are plain level signals. No stream flows through the block, so no port uses a valid/ready handshake.

Top module: `fltsig_ctrl`

## Requirements
- R1: After reset the block holds the following values. Every register reads 0. `fault_pin_oe` is 0, `fault_pin` is 0 and `fault_active` is 0. Registers: address 0 is control, with bit0 enable, bit1 heartbeat mode (1) or fault mode (0), bit2 output enable and bit3 external-input enable. Address 1 is the delay count. Address 2 is the heartbeat period. Address 3 is status, with bit0 fault-active.
- R2: `fault_pin_oe` equals the output-enable bit. While that bit is 0, `fault_pin` is 0.
- R3: In fault mode with output enabled, `fault_pin` equals the fault-active state.
- R4: In heartbeat mode, while the block is enabled and no fault is active, `fault_pin` toggles every P+1 clock cycles, where P is the period register.
- R5: In heartbeat mode the pin holds its level for as long as fault-active is set.
- R6: The fault condition is the enable bit AND (any `src_fault` bit, OR `ext_fault` when the input enable is set). Fault-active sets on the (D+1)-th consecutive rising edge at which the condition holds, where D is the delay register. Any cycle without the condition restarts the count.
- R7: A control write that sets the input-enable bit is ignored for that bit while the block is enabled. The bit keeps its previous value.
- R8: The input-enable bit can only be 1 while fault mode is selected. A write that selects heartbeat mode leaves it 0.
- R9: A control write that sets the enable bit while fault-active is set leaves the enable bit at its previous value.
- R10: Fault-active is sticky. Writing 1 to status bit0 clears it when no new fault condition is present. It also clears by itself one cycle after the block is disabled with every fault line low.
- R11: `ext_fault` contributes to the fault condition only while the input-enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| src_fault | input | N_SRC | Fault lines from system sources |
| ext_fault | input | 1 | Fault line from an external device |
| fault_pin | output | 1 | Fault/heartbeat pin level |
| fault_pin_oe | output | 1 | Pin drive enable |
| fault_active | output | 1 | Sticky fault-active state |

## Verification
On every cycle, the assertions check the following relations:
- the enable bit never rises while a fault was latched;
- the input-enable bit never rises while the block was running, and is never set outside fault mode;
- fault-active rises only from an expired delay count under a live fault condition;
- the heartbeat level stays frozen while a fault is active.

Only the bench scenarios can show the timing behaviour. This covers the exact delay length for several counts, the restart after a broken fault pulse, and the measured heartbeat period. The same applies to the clearing paths and to the external input being gated by its enable.

// File: rtl/fltsig_pkg.sv
package fltsig_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_DLY  = 2'd1,
    ADR_PER  = 2'd2,
    ADR_STAT = 2'd3
  } adr_e;

  typedef struct packed {
    logic in_en;
    logic out_en;
    logic hb_mode;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/fltsig_regs.sv
module fltsig_regs
  import fltsig_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DLY_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             active_i,
  output ctrl_t            ctrl_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [PER_W-1:0] per_o,
  output logic             clr_o
);
  ctrl_t            ctrl_q, wc;
  logic [DLY_W-1:0] dly_q;
  logic [PER_W-1:0] per_q;

  assign wc = ctrl_t'(wr_data[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dly_q  <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      unique case (adr_e'(wr_addr))
        ADR_CTRL: begin
          ctrl_q.hb_mode <= wc.hb_mode;
          ctrl_q.out_en  <= wc.out_en;
          ctrl_q.enable  <= wc.enable & (ctrl_q.enable | ~active_i);
          ctrl_q.in_en   <= wc.in_en & ~wc.hb_mode & (ctrl_q.in_en | ~ctrl_q.enable);
        end
        ADR_DLY: dly_q <= wr_data[DLY_W-1:0];
        ADR_PER: per_q <= wr_data[PER_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o  = wr_en && (adr_e'(wr_addr) == ADR_STAT) && wr_data[0];
  assign ctrl_o = ctrl_q;
  assign dly_o  = dly_q;
  assign per_o  = per_q;

  always_comb begin
    unique case (adr_e'(rd_addr))
      ADR_CTRL: rd_data = DW'(ctrl_q);
      ADR_DLY:  rd_data = DW'(dly_q);
      ADR_PER:  rd_data = DW'(per_q);
      default:  rd_data = DW'(active_i);
    endcase
  end

  AST_EN_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.enable) |-> !$past(active_i)); // R9
  AST_IN_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.in_en) |-> !$past(ctrl_q.enable)); // R7
  AST_IN_FAULT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.in_en |-> !ctrl_q.hb_mode); // R8
endmodule

// File: rtl/fltsig_delay.sv
module fltsig_delay #(
  parameter int N_SRC = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             in_en_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic             ext_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             clr_i,
  output logic             active_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             active_q;
  logic             any_src, trig, set, auto_clr;

  assign any_src  = (|src_i) | (in_en_i & ext_i);
  assign trig     = enable_i & any_src;
  assign set      = trig && (cnt_q == '0);
  assign auto_clr = ~enable_i & ~any_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (!trig)              cnt_q <= dly_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      active_q <= set | (active_q & ~clr_i & ~auto_clr);
    end
  end

  assign active_o = active_q;

  AST_SET_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(trig && cnt_q == '0)); // R6
  AST_NO_SET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(enable_i)); // R6
endmodule

// File: rtl/fltsig_beat.sv
module fltsig_beat #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             hb_mode_i,
  input  logic             out_en_i,
  input  logic             active_i,
  input  logic [PER_W-1:0] per_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic [PER_W-1:0] hb_cnt_q;
  logic             lvl_q;
  logic             run;

  assign run = enable_i & hb_mode_i & ~active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_cnt_q <= '0;
      lvl_q    <= 1'b0;
    end else if (!run) begin
      hb_cnt_q <= '0;
    end else if (hb_cnt_q >= per_i) begin
      hb_cnt_q <= '0;
      lvl_q    <= ~lvl_q;
    end else begin
      hb_cnt_q <= hb_cnt_q + 1'b1;
    end
  end

  assign pin_oe_o = out_en_i;
  assign pin_o    = out_en_i & (hb_mode_i ? lvl_q : active_i);

  AST_HB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_i) |-> lvl_q == $past(lvl_q)); // R5
  AST_HB_EDGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> $past(run && hb_cnt_q >= per_i)); // R4
endmodule

// File: rtl/fltsig_ctrl.sv
module fltsig_ctrl
  import fltsig_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int DW    = 32,
  parameter int DLY_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [N_SRC-1:0] src_fault,
  input  logic             ext_fault,
  output logic             fault_pin,
  output logic             fault_pin_oe,
  output logic             fault_active
);
  ctrl_t            ctrl;
  logic [DLY_W-1:0] dly;
  logic [PER_W-1:0] per;
  logic             clr, active;

  fltsig_regs #(.DW(DW), .DLY_W(DLY_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .active_i(active),
    .ctrl_o(ctrl), .dly_o(dly), .per_o(per), .clr_o(clr)
  );

  fltsig_delay #(.N_SRC(N_SRC), .DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .enable_i(ctrl.enable), .in_en_i(ctrl.in_en),
    .src_i(src_fault), .ext_i(ext_fault), .dly_i(dly), .clr_i(clr), .active_o(active)
  );

  fltsig_beat #(.PER_W(PER_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .enable_i(ctrl.enable), .hb_mode_i(ctrl.hb_mode),
    .out_en_i(ctrl.out_en), .active_i(active), .per_i(per),
    .pin_o(fault_pin), .pin_oe_o(fault_pin_oe)
  );

  assign fault_active = active;
endmodule

// File: tb/test_fltsig_ctrl.sv
module test_fltsig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_fault = '0;
  logic        ext_fault = 1'b0;
  logic        fault_pin, fault_pin_oe, fault_active;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fltsig_ctrl i_fltsig_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_fault(src_fault), .ext_fault(ext_fault),
    .fault_pin(fault_pin), .fault_pin_oe(fault_pin_oe), .fault_active(fault_active)
  );

  // {delay D, cycles held H, expected active}
  localparam logic [47:0] VEC [8] = '{
    {16'd0, 16'd1, 16'd1}, {16'd3, 16'd3, 16'd0}, {16'd3, 16'd4, 16'd1},
    {16'd5, 16'd5, 16'd0}, {16'd5, 16'd6, 16'd1}, {16'd1, 16'd1, 16'd0},
    {16'd1, 16'd2, 16'd1}, {16'd7, 16'd20, 16'd1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic reset_fault();
    src_fault = '0; ext_fault = 1'b0;
    wr(2'd0, 32'h0);
    tick(1);
    wr(2'd3, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic        p0;
    int          gap;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      chk("R1 reg", r, 0);
    end
    chk("R1 oe", fault_pin_oe, 0);
    chk("R1 pin", fault_pin, 0);
    chk("R1 active", fault_active, 0);

    // R6 vector table: delay length
    for (int i = 0; i < 8; i++) begin
      reset_fault();
      wr(2'd1, {16'd0, VEC[i][47:32]});
      wr(2'd0, 32'h1);
      src_fault = 8'h01 << (i % 8);
      tick(int'(VEC[i][31:16]));
      chk("R6 delay vector", fault_active, VEC[i][15:0]);
      src_fault = '0;
    end

    // R10 sticky, then write-one-to-clear
    tick(2);
    chk("R10 sticky", fault_active, 1);
    wr(2'd3, 32'h1);
    chk("R10 w1c", fault_active, 0);

    // R6 restart on a broken pulse
    reset_fault();
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h1);
    src_fault = 8'h80; tick(3);
    src_fault = '0;    tick(1);
    src_fault = 8'h80; tick(3);
    chk("R6 restart", fault_active, 0);
    tick(2);
    chk("R6 after restart", fault_active, 1);

    // R9 enable blocked while active; R10 auto clear
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h1);
    rd(2'd0, r);
    chk("R9 enable blocked", r, 32'h0);
    src_fault = '0;
    tick(1);
    chk("R10 auto clear", fault_active, 0);
    wr(2'd0, 32'h1);
    rd(2'd0, r);
    chk("R9 enable allowed", r, 32'h1);

    // R7 input enable while running ignored
    wr(2'd0, 32'h9);
    rd(2'd0, r);
    chk("R7 in_en ignored", r, 32'h1);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h9);
    rd(2'd0, r);
    chk("R7 in_en accepted", r, 32'h9);
    // R8 input enable needs fault mode
    wr(2'd0, 32'h0);
    wr(2'd0, 32'hB);
    rd(2'd0, r);
    chk("R8 in_en with heartbeat", r, 32'h3);

    // R11 external input gated by input enable
    reset_fault();
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h1);
    ext_fault = 1'b1; tick(3);
    chk("R11 ext ignored", fault_active, 0);
    reset_fault();
    wr(2'd0, 32'h9);
    ext_fault = 1'b1; tick(1);
    chk("R11 ext fault", fault_active, 1);

    // R2 output enable off
    chk("R2 oe off", fault_pin_oe, 0);
    chk("R2 pin off", fault_pin, 0);
    // R3 fault mode pin follows active
    wr(2'd0, 32'hD);
    chk("R2 oe on", fault_pin_oe, 1);
    chk("R3 pin active", fault_pin, 1);
    ext_fault = 1'b0;
    wr(2'd3, 32'h1);
    chk("R3 pin idle", fault_pin, 0);

    // R4 heartbeat period
    reset_fault();
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h7);
    p0 = fault_pin;
    gap = 0;
    while (fault_pin == p0 && gap < 20) begin tick(1); gap++; end
    for (int k = 0; k < 2; k++) begin
      p0 = fault_pin; gap = 0;
      while (fault_pin == p0 && gap < 20) begin tick(1); gap++; end
      chk("R4 period", gap, 4);
    end

    // R5 hold on fault
    wr(2'd1, 32'd0);
    src_fault = 8'h04; tick(1);
    chk("R5 active", fault_active, 1);
    p0 = fault_pin;
    tick(12);
    chk("R5 hold", fault_pin, p0);
    src_fault = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule